// File: doc/BRIEF.md
# Line-Tagged Receive Queue with Low-Priority Admission

This block is the shared receive queue of a four-line serial multiplexer. Every receiver on the multiplexer pushes a character together with the number of the line it came in on, and the host-side register logic pops one entry per read. The character and its line number leave the queue together, in arrival order.

The queue reports how many entries it holds, whether it is empty, and whether an entry was lost because no slot was free. One line, chosen by a parameter, is treated as low priority. Once the queue is more than half full, pushes from that line are thrown away without raising any error. This keeps chatty traffic on that line from crowding out the others. The depth is a power-of-two parameter. One slot always stays free, so a queue of depth D holds at most D-1 entries.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: A pop on a non-empty queue presents the oldest entry's 8-bit character on `pop_char_o` and its 2-bit line number on `pop_line_o`, with `pop_valid_o` high, in the cycle after the pop; entries leave in the order they were accepted.
- R2: `count_o` equals accepted pushes minus honoured pops, ranges from 0 to DEPTH-1, and stays correct as the pointers wrap past the end of storage.
- R3: `empty_o` is high exactly when `count_o` is 0.
- R4: A pop on an empty queue gives `pop_valid_o` = 0, `pop_char_o` = 0 and `pop_line_o` = 0 in the next cycle and leaves `count_o` unchanged.
- R5: A push whose line equals LOW_LINE (default 3) while `count_o` > DEPTH/2 is discarded: `count_o` does not change, `overrun_o` does not set, and the character never appears at the output.
- R6: A push from any other line, or from LOW_LINE while `count_o` <= DEPTH/2, is accepted while `count_o` < DEPTH-1.
- R7: A push that passes the admission rule while `count_o` = DEPTH-1 and no pop is honoured in the same cycle sets `overrun_o` in the next cycle; the entry is discarded and the queued entries are kept intact.
- R8: `overrun_o` stays set until `ovr_clr_i` is high at a clock edge; if a new overrun and a clear happen in the same cycle, the flag ends up set.
- R9: A push and a pop in the same cycle on a non-empty queue are both honoured and `count_o` is unchanged, including when the queue holds DEPTH-1 entries.
- R10: After reset, `count_o` = 0, `empty_o` = 1, `overrun_o` = 0 and `pop_valid_o` = 0, with `pop_char_o` and `pop_line_o` zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request from a line receiver |
| push_char_i | input | 8 | Character to queue |
| push_line_i | input | 2 | Line number the character arrived on |
| pop_i | input | 1 | Pop request from the host-side read |
| ovr_clr_i | input | 1 | Clears the sticky overrun flag |
| pop_char_o | output | 8 | Character of the popped entry, zero if none |
| pop_line_o | output | 2 | Line number of the popped entry, zero if none |
| pop_valid_o | output | 1 | High the cycle after a pop that returned an entry |
| count_o | output | log2(DEPTH) | Number of entries held |
| empty_o | output | 1 | Queue holds no entry |
| overrun_o | output | 1 | Sticky flag: an entry was lost to a full queue |

## Verification
The queue is driven with interleaved pushes and pops from all four lines, which distinguishes correct order and tagging from swapped or stale fields, and with combined push-and-pop cycles at empty, partial and full occupancy, which exposes pointer or counter updates that are applied only once. The low-priority line is pushed exactly at the half-full mark and one entry above it, so an off-by-one in the admission threshold shows up as an extra or missing entry in the drained sequence. The full queue is pushed to raise the overrun flag, then drained completely to confirm that the rejected character never appears. A clear that coincides with a fresh overrun separates set-priority from clear-priority.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    parameter int RXQ_CHAR_W = 8;
    parameter int RXQ_LINE_W = 2;

    typedef struct packed {
        logic [RXQ_CHAR_W-1:0] ch;
        logic [RXQ_LINE_W-1:0] line;
    } rxq_entry_t;

endpackage

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl
    import rxq_pkg::*;
#(
    parameter int                  DEPTH    = 16,
    parameter logic [RXQ_LINE_W-1:0] LOW_LINE = 2'd3,
    localparam int                 AW       = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [RXQ_LINE_W-1:0] push_line_i,
    input  logic                  pop_i,
    input  logic                  ovr_clr_i,
    output logic                  wr_en_o,
    output logic [AW-1:0]         wr_addr_o,
    output logic [AW-1:0]         rd_addr_o,
    output logic                  rd_fire_o,
    output logic [AW-1:0]         count_o,
    output logic                  empty_o,
    output logic                  overrun_o
);

    localparam logic [AW-1:0] HALF = AW'(DEPTH / 2);
    localparam logic [AW-1:0] FULL = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic          ovr;
    } ctrl_t;

    ctrl_t st_q, st_d;

    logic [AW-1:0] occ;
    logic          is_empty;
    logic          is_full;
    logic          low_block;
    logic          want_push;
    logic          take_pop;
    logic          lost;
    logic          do_write;

    always_comb begin
        occ       = st_q.wr - st_q.rd;
        is_empty  = (st_q.wr == st_q.rd);
        is_full   = (occ == FULL);
        low_block = (push_line_i == LOW_LINE) && (occ > HALF);
        want_push = push_i && !low_block;
        take_pop  = pop_i && !is_empty;
        lost      = want_push && is_full && !take_pop;
        do_write  = want_push && !lost;

        st_d = st_q;
        if (do_write) begin
            st_d.wr = st_q.wr + AW'(1);
        end
        if (take_pop) begin
            st_d.rd = st_q.rd + AW'(1);
        end
        if (lost) begin
            st_d.ovr = 1'b1;
        end else if (ovr_clr_i) begin
            st_d.ovr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = do_write;
    assign wr_addr_o = st_q.wr;
    assign rd_addr_o = st_q.rd;
    assign rd_fire_o = take_pop;
    assign count_o   = occ;
    assign empty_o   = is_empty;
    assign overrun_o = st_q.ovr;

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_o == $past(count_o)) ||
                 (count_o == $past(count_o) + AW'(1)) ||
                 (count_o == $past(count_o) - AW'(1)));

    // R5
    low_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && push_line_i == LOW_LINE && count_o > HALF && !pop_i)
        |=> (count_o == $past(count_o)) && (overrun_o == $past(overrun_o)));

    // R7
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && push_line_i != LOW_LINE && count_o == FULL && !pop_i)
        |=> overrun_o && (count_o == FULL));

    // R8
    overrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !ovr_clr_i) |=> overrun_o);

    // R9
    pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o && push_line_i != LOW_LINE)
        |=> $stable(count_o));

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int  DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  rxq_entry_t wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output rxq_entry_t rd_data_o
);

    rxq_entry_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem_q[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_addr_i];

endmodule

// File: rtl/rxq_pop_stage.sv
module rxq_pop_stage
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire_i,
    input  rxq_entry_t head_i,
    output logic       valid_o,
    output rxq_entry_t data_o
);

    typedef struct packed {
        logic       valid;
        rxq_entry_t data;
    } out_t;

    out_t out_q, out_d;

    always_comb begin
        out_d.valid = fire_i;
        out_d.data  = fire_i ? head_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign valid_o = out_q.valid;
    assign data_o  = out_q.data;

endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int                    DEPTH    = 16,
    parameter logic [RXQ_LINE_W-1:0] LOW_LINE = 2'd3,
    localparam int                   AW       = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_i,
    input  logic [RXQ_CHAR_W-1:0] push_char_i,
    input  logic [RXQ_LINE_W-1:0] push_line_i,
    input  logic                  pop_i,
    input  logic                  ovr_clr_i,
    output logic [RXQ_CHAR_W-1:0] pop_char_o,
    output logic [RXQ_LINE_W-1:0] pop_line_o,
    output logic                  pop_valid_o,
    output logic [AW-1:0]         count_o,
    output logic                  empty_o,
    output logic                  overrun_o
);

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;
    logic          rd_fire;
    rxq_entry_t    wr_entry;
    rxq_entry_t    head;
    rxq_entry_t    out_entry;

    assign wr_entry.ch   = push_char_i;
    assign wr_entry.line = push_line_i;

    rxq_ptr_ctrl #(
        .DEPTH    (DEPTH),
        .LOW_LINE (LOW_LINE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_line_i (push_line_i),
        .pop_i       (pop_i),
        .ovr_clr_i   (ovr_clr_i),
        .wr_en_o     (wr_en),
        .wr_addr_o   (wr_addr),
        .rd_addr_o   (rd_addr),
        .rd_fire_o   (rd_fire),
        .count_o     (count_o),
        .empty_o     (empty_o),
        .overrun_o   (overrun_o)
    );

    rxq_store #(
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_entry),
        .rd_addr_i (rd_addr),
        .rd_data_o (head)
    );

    rxq_pop_stage u_pop (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (rd_fire),
        .head_i  (head),
        .valid_o (pop_valid_o),
        .data_o  (out_entry)
    );

    assign pop_char_o = out_entry.ch;
    assign pop_line_o = out_entry.line;

    // R1
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !empty_o) |=> pop_valid_o);

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o) |=> !pop_valid_o && pop_char_o == '0 &&
                               pop_line_o == '0);

    // R3
    empty_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && !push_i) |=> empty_o && count_o == '0);

endmodule

// File: tb/rxq_tagged_fifo_bench.sv
module rxq_tagged_fifo_bench;

    localparam int DEPTH = 16;
    localparam int AW    = 4;
    localparam int NVEC  = 10;

    typedef struct packed {
        logic          push;
        logic [7:0]    ch;
        logic [1:0]    line;
        logic          pop;
        logic          ev;
        logic [7:0]    ec;
        logic [1:0]    el;
        logic [AW-1:0] ecnt;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 8'hA5, 2'd1, 1'b0, 1'b0, 8'h00, 2'd0, 4'd1},
        '{1'b1, 8'h3C, 2'd2, 1'b0, 1'b0, 8'h00, 2'd0, 4'd2},
        '{1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 8'hA5, 2'd1, 4'd1},
        '{1'b1, 8'h7E, 2'd3, 1'b1, 1'b1, 8'h3C, 2'd2, 4'd1},
        '{1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 8'h7E, 2'd3, 4'd0},
        '{1'b0, 8'h00, 2'd0, 1'b1, 1'b0, 8'h00, 2'd0, 4'd0},
        '{1'b1, 8'h42, 2'd0, 1'b1, 1'b0, 8'h00, 2'd0, 4'd1},
        '{1'b1, 8'h99, 2'd3, 1'b0, 1'b0, 8'h00, 2'd0, 4'd2},
        '{1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 8'h42, 2'd0, 4'd1},
        '{1'b0, 8'h00, 2'd0, 1'b1, 1'b1, 8'h99, 2'd3, 4'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0;
    logic [7:0]    push_char_i = '0;
    logic [1:0]    push_line_i = '0;
    logic          pop_i = 1'b0;
    logic          ovr_clr_i = 1'b0;
    logic [7:0]    pop_char_o;
    logic [1:0]    pop_line_o;
    logic          pop_valid_o;
    logic [AW-1:0] count_o;
    logic          empty_o;
    logic          overrun_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rxq_tagged_fifo #(
        .DEPTH    (DEPTH),
        .LOW_LINE (2'd3)
    ) u_rxq_tagged_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push_i),
        .push_char_i (push_char_i),
        .push_line_i (push_line_i),
        .pop_i       (pop_i),
        .ovr_clr_i   (ovr_clr_i),
        .pop_char_o  (pop_char_o),
        .pop_line_o  (pop_line_o),
        .pop_valid_o (pop_valid_o),
        .count_o     (count_o),
        .empty_o     (empty_o),
        .overrun_o   (overrun_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input logic p, input logic [7:0] c, input logic [1:0] l,
                        input logic q, input logic clr);
        push_i      = p;
        push_char_i = c;
        push_line_i = l;
        pop_i       = q;
        ovr_clr_i   = clr;
        @(posedge clk);
        @(negedge clk);
        push_i    = 1'b0;
        pop_i     = 1'b0;
        ovr_clr_i = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [7:0] c,
                              input logic [1:0] l);
        step(1'b0, 8'h00, 2'd0, 1'b1, 1'b0);
        check({req, " valid"}, int'(pop_valid_o), 1);
        check({req, " char"}, int'(pop_char_o), int'(c));
        check({req, " line"}, int'(pop_line_o), int'(l));
    endtask

    task automatic reset_checks(input string tag);
        check({"R10 count ", tag}, int'(count_o), 0);
        check({"R10 empty ", tag}, int'(empty_o), 1);
        check({"R10 overrun ", tag}, int'(overrun_o), 0);
        check({"R10 valid ", tag}, int'(pop_valid_o), 0);
        check({"R10 char ", tag}, int'(pop_char_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("power-up");

        // table walk: R1, R2, R3, R4, R6, R9 under mixed patterns
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i].push, VEC[i].ch, VEC[i].line, VEC[i].pop, 1'b0);
            check("R2 count", int'(count_o), int'(VEC[i].ecnt));
            check("R3 empty", int'(empty_o), int'(VEC[i].ecnt == 0));
            if (VEC[i].pop) begin
                check("R1/R4 valid", int'(pop_valid_o), int'(VEC[i].ev));
                check("R1/R4 char", int'(pop_char_o), int'(VEC[i].ec));
                check("R1/R4 line", int'(pop_line_o), int'(VEC[i].el));
            end
        end

        // admission threshold: R5, R6
        for (int i = 0; i < 8; i++) step(1'b1, 8'h10 + 8'(i), 2'd0, 1'b0, 1'b0);
        check("R6 count at half", int'(count_o), 8);
        step(1'b1, 8'hEE, 2'd3, 1'b0, 1'b0);
        check("R6 low line at half accepted", int'(count_o), 9);
        step(1'b1, 8'hDD, 2'd3, 1'b0, 1'b0);
        check("R5 low line above half dropped", int'(count_o), 9);
        check("R5 no overrun", int'(overrun_o), 0);
        step(1'b1, 8'hCC, 2'd2, 1'b0, 1'b0);
        check("R6 other line above half", int'(count_o), 10);
        for (int i = 0; i < 8; i++) pop_expect("R1 drain", 8'h10 + 8'(i), 2'd0);
        pop_expect("R5 order", 8'hEE, 2'd3);
        pop_expect("R5 dropped absent", 8'hCC, 2'd2);
        check("R3 empty after drain", int'(empty_o), 1);

        // full queue: R7, R8, R9
        for (int i = 0; i < 15; i++) step(1'b1, 8'h40 + 8'(i), 2'd1, 1'b0, 1'b0);
        check("R2 count full", int'(count_o), 15);
        check("R7 no overrun yet", int'(overrun_o), 0);
        step(1'b1, 8'hFF, 2'd1, 1'b0, 1'b0);
        check("R7 overrun set", int'(overrun_o), 1);
        check("R7 count kept", int'(count_o), 15);
        step(1'b0, 8'h00, 2'd0, 1'b0, 1'b0);
        check("R8 sticky", int'(overrun_o), 1);
        step(1'b1, 8'hAB, 2'd2, 1'b1, 1'b0);
        check("R9 count full push+pop", int'(count_o), 15);
        check("R9 popped head", int'(pop_char_o), 8'h40);
        check("R9 no extra overrun", int'(overrun_o), 1);
        step(1'b0, 8'h00, 2'd0, 1'b0, 1'b1);
        check("R8 cleared", int'(overrun_o), 0);
        for (int i = 1; i < 15; i++) pop_expect("R7 intact", 8'h40 + 8'(i), 2'd1);
        pop_expect("R7 lost entry absent", 8'hAB, 2'd2);
        step(1'b0, 8'h00, 2'd0, 1'b1, 1'b0);
        check("R4 empty pop valid", int'(pop_valid_o), 0);
        check("R4 empty pop char", int'(pop_char_o), 0);
        check("R4 empty pop line", int'(pop_line_o), 0);
        check("R4 count unchanged", int'(count_o), 0);

        // set beats clear: R8
        for (int i = 0; i < 15; i++) step(1'b1, 8'h60 + 8'(i), 2'd0, 1'b0, 1'b0);
        step(1'b1, 8'h77, 2'd0, 1'b0, 1'b1);
        check("R8 set wins over clear", int'(overrun_o), 1);
        step(1'b0, 8'h00, 2'd0, 1'b0, 1'b1);
        check("R8 clear alone", int'(overrun_o), 0);

        // reset mid-run: R10
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks("mid-run");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule